// File: doc/BRIEF.md
# Four-Channel Programmable Timer Bank

Four independent 16-bit up-counters share one memory-mapped register window. A plain synchronous bus (select, write enable, address, write data, registered read data) reaches every timer. Address bits 12:11 pick the timer. Address bits 5:4 then pick one of its registers: count, mode, compare or hold.

Each timer advances on the shared clock-enable `tick` while its mode word enables counting. A timer records two events in sticky flags inside its mode word: reaching its compare value and wrapping from 0xFFFF to 0x0000. With zero-return enabled, a compare match sends the count back to zero. Only timers 0 and 1 have a hold register, which captures the matched count. Each timer drives its own interrupt line from its flags and their enables.

Software uses the bank as a periodic tick source or an event counter. It programs compare and mode, enables the interrupts it needs, and acknowledges each event by writing a 1 to the flag bit.

Top module: `timer_bank`

## Requirements
- R1: Address bits 12:11 select the timer. Within a timer, offset 0x00 is count, 0x10 is mode, 0x20 is compare and 0x30 is hold. An address with any other bit in 10:6 or 3:0 set is unmapped: writes to it are ignored and reads return 0. Read data appears on `busRdata` in the cycle after the read request and is 0 in every other cycle.
- R2: After reset, every count, mode, compare and hold register reads 0 and every `irq` bit is 0.
- R3: A count advances by one on a clock with `tick` high only while its mode bit 7 (count enable) is set. Otherwise it keeps its value.
- R4: A count write takes effect on the next clock edge. It overrides a tick in the same cycle, and that cycle raises no compare or wrap event.
- R5: A tick with the count at 0xFFFF wraps the count to 0x0000 and sets the wrap flag, mode bit 11.
- R6: A tick that brings the count equal to compare sets the compare flag, mode bit 10. When mode bit 6 (zero-return) is set, the count becomes 0 instead of the compare value.
- R7: On timers 0 and 1, hold is writable and captures the matched count on a compare match. On timers 2 and 3, hold reads 0 and writes to it are ignored.
- R8: Writing 1 to mode bit 10 or bit 11 clears that flag, and writing 0 leaves it unchanged. An event in the same cycle as a clearing write leaves the flag set.
- R9: Mode bit 8 enables the compare interrupt and bit 9 enables the wrap interrupt. A timer's `irq` bit is high exactly when an enabled flag is set. It rises in the cycle after the event and does not rise for a flag whose enable is clear.
- R10: Mode bits 6 to 9 are read/write and bits 10 and 11 are the flags. All other mode bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count clock-enable shared by all timers |
| busSel | input | 1 | Bus access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 13 | Byte address within the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| irq | output | 4 | Interrupt line per timer |

## Verification
Every register update happens at the clock edge where its cause is presented. A count, flag or hold change is therefore visible one cycle after the write or tick. A bus read returns its data in the next cycle, so a check on a register reads it back through the bus two cycles after the stimulus. An `irq` change follows the causing edge combinationally. The bench drives inputs on falling edges and samples on the next falling edge, so each result is taken exactly where these latencies place it. The bench sweeps all four timers through each scenario and computes the expected counts and mode words arithmetically.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  // Mode word bit positions
  localparam int MB_ZRET = 6;
  localparam int MB_CUE  = 7;
  localparam int MB_CMPE = 8;
  localparam int MB_OVFE = 9;
  localparam int MB_CMPF = 10;
  localparam int MB_OVFF = 11;

  typedef enum logic [1:0] {
    REG_COUNT = 2'd0,
    REG_MODE  = 2'd1,
    REG_COMP  = 2'd2,
    REG_HOLD  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrCount;
    logic wrMode;
    logic wrComp;
    logic wrHold;
  } timerStrobe_t;
endpackage

// File: rtl/timer_bank_ctrl.sv
module timer_bank_ctrl
  import timer_bank_pkg::*;
#(
  parameter int NUM_TIMERS  = 4,
  parameter int TIMER_SHIFT = 11,
  parameter int REG_SHIFT   = 4,
  localparam int IDX_W      = $clog2(NUM_TIMERS),
  localparam int ADDR_W     = TIMER_SHIFT + IDX_W
) (
  input  logic                               busSel,
  input  logic                               busWrite,
  input  logic [ADDR_W-1:0]                  busAddr,
  output timerStrobe_t [NUM_TIMERS-1:0]      strobes,
  output logic                               rdEn,
  output logic [IDX_W-1:0]                   rdTimer,
  output regSel_e                            rdReg
);
  logic [IDX_W-1:0] timerIdx;
  logic             mapped;
  regSel_e          regIdx;

  assign timerIdx = busAddr[TIMER_SHIFT +: IDX_W];
  assign regIdx   = regSel_e'(busAddr[REG_SHIFT +: 2]);
  assign mapped   = (busAddr[TIMER_SHIFT-1:REG_SHIFT+2] == '0) &&
                    (busAddr[REG_SHIFT-1:0] == '0);

  always_comb begin
    for (int i = 0; i < NUM_TIMERS; i++) begin
      strobes[i] = '0;
      if (busSel && busWrite && mapped && (timerIdx == IDX_W'(i))) begin
        strobes[i].wrCount = (regIdx == REG_COUNT);
        strobes[i].wrMode  = (regIdx == REG_MODE);
        strobes[i].wrComp  = (regIdx == REG_COMP);
        strobes[i].wrHold  = (regIdx == REG_HOLD);
      end
    end
  end

  assign rdEn    = busSel && !busWrite && mapped;
  assign rdTimer = timerIdx;
  assign rdReg   = regIdx;
endmodule

// File: rtl/timer_bank_dp.sv
module timer_bank_dp
  import timer_bank_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int NUM_HOLD   = 2,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 32,
  localparam int IDX_W     = $clog2(NUM_TIMERS)
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 tick,
  input  timerStrobe_t [NUM_TIMERS-1:0]        strobes,
  input  logic [DATA_W-1:0]                    wdata,
  input  logic                                 rdEn,
  input  logic [IDX_W-1:0]                     rdTimer,
  input  regSel_e                              rdReg,
  output logic [DATA_W-1:0]                    rdata,
  output logic [NUM_TIMERS-1:0]                irq,
  output logic [NUM_TIMERS-1:0][CNT_W-1:0]     cntVec,
  output logic [NUM_TIMERS-1:0][15:0]          modeVec
);
  logic [NUM_TIMERS-1:0][CNT_W-1:0] compVec;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] holdVec;

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_timer
    logic [CNT_W-1:0] cnt, comp, incVal;
    logic [5:0]       modeR;   // mode bits 11..6
    logic             stepping, match, wrap;

    assign incVal   = cnt + 1'b1;
    assign stepping = tick && modeR[MB_CUE-6] && !strobes[i].wrCount;
    assign match    = stepping && (incVal == comp);
    assign wrap     = stepping && (cnt == '1);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt   <= '0;
        comp  <= '0;
        modeR <= '0;
      end else begin
        if (strobes[i].wrCount)
          cnt <= wdata[CNT_W-1:0];
        else if (stepping)
          cnt <= (match && modeR[MB_ZRET-6]) ? '0 : incVal;
        if (strobes[i].wrComp)
          comp <= wdata[CNT_W-1:0];
        if (strobes[i].wrMode)
          modeR[3:0] <= wdata[MB_OVFE:MB_ZRET];
        modeR[MB_CMPF-6] <= match ||
          (modeR[MB_CMPF-6] && !(strobes[i].wrMode && wdata[MB_CMPF]));
        modeR[MB_OVFF-6] <= wrap ||
          (modeR[MB_OVFF-6] && !(strobes[i].wrMode && wdata[MB_OVFF]));
      end
    end

    if (i < NUM_HOLD) begin : g_hold
      logic [CNT_W-1:0] hold;
      always_ff @(posedge clk) begin
        if (!rstN)
          hold <= '0;
        else if (match)
          hold <= incVal;
        else if (strobes[i].wrHold)
          hold <= wdata[CNT_W-1:0];
      end
      assign holdVec[i] = hold;
    end else begin : g_nohold
      assign holdVec[i] = '0;
    end

    assign cntVec[i]  = cnt;
    assign compVec[i] = comp;
    assign modeVec[i] = {4'b0, modeR, 6'b0};
    assign irq[i] = (modeR[MB_CMPF-6] && modeR[MB_CMPE-6]) ||
                    (modeR[MB_OVFF-6] && modeR[MB_OVFE-6]);
  end

  logic [DATA_W-1:0] rdMux;
  always_comb begin
    unique case (rdReg)
      REG_COUNT: rdMux = DATA_W'(cntVec[rdTimer]);
      REG_MODE:  rdMux = DATA_W'(modeVec[rdTimer]);
      REG_COMP:  rdMux = DATA_W'(compVec[rdTimer]);
      default:   rdMux = DATA_W'(holdVec[rdTimer]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rdata <= '0;
    else
      rdata <= rdEn ? rdMux : '0;
  end
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int NUM_HOLD   = 2,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 32,
  localparam int IDX_W     = $clog2(NUM_TIMERS),
  localparam int ADDR_W    = 11 + IDX_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  logic                  busSel,
  input  logic                  busWrite,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  output logic [NUM_TIMERS-1:0] irq
);
  timerStrobe_t [NUM_TIMERS-1:0]    strobes;
  logic                             rdEn;
  logic [IDX_W-1:0]                 rdTimer;
  regSel_e                          rdReg;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] cntVec;
  logic [NUM_TIMERS-1:0][15:0]      modeVec;

  timer_bank_ctrl #(.NUM_TIMERS(NUM_TIMERS), .TIMER_SHIFT(11), .REG_SHIFT(4)) ctrl_i (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .strobes(strobes), .rdEn(rdEn), .rdTimer(rdTimer), .rdReg(rdReg)
  );

  timer_bank_dp #(.NUM_TIMERS(NUM_TIMERS), .NUM_HOLD(NUM_HOLD),
                  .CNT_W(CNT_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .tick(tick), .strobes(strobes), .wdata(busWdata),
    .rdEn(rdEn), .rdTimer(rdTimer), .rdReg(rdReg), .rdata(busRdata),
    .irq(irq), .cntVec(cntVec), .modeVec(modeVec)
  );
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk #(
  parameter int NUM_TIMERS = 4,
  parameter int NUM_HOLD   = 2,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 13
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             tick,
  input logic                             busSel,
  input logic                             busWrite,
  input logic [ADDR_W-1:0]                busAddr,
  input logic [DATA_W-1:0]                busRdata,
  input logic [NUM_TIMERS-1:0]            irq,
  input logic [NUM_TIMERS-1:0][CNT_W-1:0] cntVec,
  input logic [NUM_TIMERS-1:0][15:0]      modeVec
);
  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWrite) |=> busRdata == '0); // R1

  AST_NO_HOLD_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && (int'(busAddr[ADDR_W-1:11]) >= NUM_HOLD) &&
     busAddr[10:0] == 11'h030) |=> busRdata == '0); // R7

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
    AST_IDLE_COUNT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
      (!tick && !busSel) |=> $stable(cntVec[i])); // R3

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (tick && modeVec[i][7] && cntVec[i] == '1 && !busSel)
        |=> (cntVec[i] == '0 && modeVec[i][11])); // R5

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      irq[i] |-> (modeVec[i][10] || modeVec[i][11])); // R9
  end
endmodule

bind timer_bank timer_bank_chk #(
  .NUM_TIMERS(NUM_TIMERS), .NUM_HOLD(NUM_HOLD), .CNT_W(CNT_W),
  .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rstN(rstN), .tick(tick), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busRdata(busRdata), .irq(irq),
  .cntVec(cntVec), .modeVec(modeVec)
);

// File: tb/timer_bank_tb.sv
module timer_bank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [12:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  timer_bank dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  localparam logic [12:0] OFF_CNT = 13'h00, OFF_MODE = 13'h10,
                          OFF_COMP = 13'h20, OFF_HOLD = 13'h30;

  function automatic logic [12:0] addrOf(int t, logic [12:0] off);
    return 13'(t * 13'h800) | off;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWr(logic [12:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic wrWithTick(logic [12:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d; tick = 1;
    @(negedge clk);
    busSel = 0; busWrite = 0; tick = 0;
  endtask

  task automatic busRd(logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    @(negedge clk);
    d = busRdata;
    busSel = 0;
  endtask

  task automatic doTicks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1;
    end
    @(negedge clk); tick = 0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R2: reset state of every register
    chk("R2 irq", 32'(irq), 0);
    for (int t = 0; t < 4; t++)
      for (int o = 0; o < 4; o++) begin
        busRd(addrOf(t, 13'(o * 16)), r);
        chk("R2 reg", r, 0);
      end

    // R1: per-timer decode, distinct values
    for (int t = 0; t < 4; t++) begin
      busWr(addrOf(t, OFF_COMP), 32'h1000 + t * 32'h111);
      busWr(addrOf(t, OFF_CNT), t * 7);
    end
    for (int t = 0; t < 4; t++) begin
      busRd(addrOf(t, OFF_COMP), r); chk("R1 comp", r, 32'h1000 + t * 32'h111);
      busRd(addrOf(t, OFF_CNT), r);  chk("R1 count", r, t * 7);
      busWr(addrOf(t, 13'h08), 32'h55);
      busWr(addrOf(t, 13'h40), 32'h66);
      busRd(addrOf(t, 13'h08), r);   chk("R1 unmapped read", r, 0);
      busRd(addrOf(t, 13'h40), r);   chk("R1 unmapped read", r, 0);
      busRd(addrOf(t, OFF_CNT), r);  chk("R1 unmapped write ignored", r, t * 7);
      @(negedge clk); chk("R1 idle rdata", busRdata, 0);
    end

    // R10: mode readback mask
    for (int t = 0; t < 4; t++) begin
      busWr(addrOf(t, OFF_MODE), 32'hFFFF);
      busRd(addrOf(t, OFF_MODE), r); chk("R10 mode mask", r, 32'h03C0);
      busWr(addrOf(t, OFF_MODE), 0);
    end

    // R3: counting enable
    for (int t = 0; t < 4; t++) begin
      busWr(addrOf(t, OFF_CNT), 0);
      busWr(addrOf(t, OFF_MODE), 32'h80);
      doTicks(t + 3);
      busRd(addrOf(t, OFF_CNT), r); chk("R3 count enabled", r, t + 3);
      busWr(addrOf(t, OFF_MODE), 0);
      doTicks(5);
      busRd(addrOf(t, OFF_CNT), r); chk("R3 count disabled", r, t + 3);
    end

    // R4: count write overrides tick
    for (int t = 0; t < 4; t++) begin
      busWr(addrOf(t, OFF_MODE), 32'h80);
      wrWithTick(addrOf(t, OFF_CNT), 32'h1234 + t);
      busRd(addrOf(t, OFF_CNT), r); chk("R4 write wins", r, 32'h1234 + t);
      busWr(addrOf(t, OFF_MODE), 0);
    end

    // R5 / R8 / R9: wrap, flag, interrupt, clear
    for (int t = 0; t < 4; t++) begin
      busWr(addrOf(t, OFF_COMP), 5);
      busWr(addrOf(t, OFF_CNT), 32'hFFFE);
      busWr(addrOf(t, OFF_MODE), 32'h280);
      doTicks(1);
      chk("R9 no irq before wrap", 32'(irq), 0);
      doTicks(1);
      chk("R9 irq on wrap", 32'(irq), 32'(1 << t));
      busRd(addrOf(t, OFF_CNT), r);  chk("R5 wrapped", r, 0);
      busRd(addrOf(t, OFF_MODE), r); chk("R5 wrap flag", r, 32'hA80);
      busWr(addrOf(t, OFF_MODE), 32'hA80);
      chk("R8 irq cleared", 32'(irq), 0);
      busRd(addrOf(t, OFF_MODE), r); chk("R8 flag cleared", r, 32'h280);
      busWr(addrOf(t, OFF_MODE), 0);
    end

    // R6 / R7: compare, hold, zero-return
    for (int t = 0; t < 4; t++) begin
      busWr(addrOf(t, OFF_COMP), 10);
      busWr(addrOf(t, OFF_HOLD), 32'hBEEF);
      busRd(addrOf(t, OFF_HOLD), r);
      chk("R7 hold write", r, (t < 2) ? 32'hBEEF : 0);
      busWr(addrOf(t, OFF_CNT), 7);
      busWr(addrOf(t, OFF_MODE), 32'h180);
      doTicks(3);
      chk("R9 irq on compare", 32'(irq), 32'(1 << t));
      busRd(addrOf(t, OFF_MODE), r); chk("R6 compare flag", r, 32'h580);
      doTicks(1);
      busRd(addrOf(t, OFF_CNT), r);  chk("R6 runs past compare", r, 11);
      busRd(addrOf(t, OFF_HOLD), r);
      chk("R7 hold capture", r, (t < 2) ? 10 : 0);
      busWr(addrOf(t, OFF_MODE), 32'h180);
      busRd(addrOf(t, OFF_MODE), r); chk("R8 write 0 keeps flag", r, 32'h580);
      busWr(addrOf(t, OFF_MODE), 32'h5C0);
      busWr(addrOf(t, OFF_HOLD), 0);
      busWr(addrOf(t, OFF_CNT), 7);
      doTicks(3);
      busRd(addrOf(t, OFF_CNT), r);  chk("R6 zero-return", r, 0);
      busRd(addrOf(t, OFF_MODE), r); chk("R6 zret flag", r, 32'h5C0);
      busRd(addrOf(t, OFF_HOLD), r);
      chk("R7 hold on zret", r, (t < 2) ? 10 : 0);
      busWr(addrOf(t, OFF_MODE), 32'h400);
    end

    // R8: event beats clearing write in the same cycle
    for (int t = 0; t < 4; t++) begin
      busWr(addrOf(t, OFF_CNT), 9);
      busWr(addrOf(t, OFF_MODE), 32'h180);
      wrWithTick(addrOf(t, OFF_MODE), 32'h580);
      busRd(addrOf(t, OFF_MODE), r); chk("R8 set wins", r, 32'h580);
      busRd(addrOf(t, OFF_CNT), r);  chk("R8 count at compare", r, 10);
      busWr(addrOf(t, OFF_MODE), 32'h400);
    end

    // R9: flag without enable gives no irq; enabling later raises it
    for (int t = 0; t < 4; t++) begin
      busWr(addrOf(t, OFF_CNT), 32'hFFFF);
      busWr(addrOf(t, OFF_MODE), 32'h80);
      doTicks(1);
      chk("R9 masked flag", 32'(irq), 0);
      busRd(addrOf(t, OFF_MODE), r); chk("R9 flag set", r, 32'h880);
      busWr(addrOf(t, OFF_MODE), 32'h200);
      chk("R9 irq after enable", 32'(irq), 32'(1 << t));
      busWr(addrOf(t, OFF_MODE), 32'h800);
      chk("R9 irq released", 32'(irq), 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule